// File: doc/BRIEF.md
# Power-Good and Thermal Supervisor

This block decides when a regulator's open-drain power-good pad may float high and when the die is too hot to keep running. It watches a handful of digital status inputs: a one-cycle pulse that marks the end of a successful soft-start, a level that is high while any fault is being handled, a level that is high while the switch current limit is engaged, and four temperature comparator flags. From these it produces a pull-low request for the power-good pad and a thermal shutdown request.

Power good is released only after soft-start has finished and stays released only while nothing is wrong. A current limit held without a break for a programmable number of microsecond ticks pulls it low. A hysteretic early-warning flag pulls it low when the die runs hot and lets go once the die has cooled well below that point. A fault pulls it low and keeps it low until soft-start completes again. A second hysteretic flag with its own pair of thresholds requests thermal shutdown. All state is registered, so every output responds one clock after the input edge that causes the change.

Top module: `pgts_supervisor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `pg_pull_low` = 1 and `thermal_shutdown` = 0, whatever the other inputs are.
- R2: After reset, `pg_pull_low` stays 1 until a clock edge samples `ss_done` = 1 with `fault_active` = 0. From the cycle after that edge, `pg_pull_low` is 0 if no other pull-low cause is present.
- R3: With `ilim_active` held at 1, each edge that samples `us_tick` = 1 counts one tick. Edges with `us_tick` = 0 do not count. From the cycle after the edge that counts the 64th tick (`ILIM_HOLD_US` = 64), `pg_pull_low` is 1. Before that edge it is not raised by the current limit.
- R4: An edge that samples `ilim_active` = 0 clears the tick count. The current-limit pull-low is gone from the next cycle, and a later hold must again collect the full number of ticks.
- R5: The early-warning flag is set by an edge that samples `hot_120` = 1. It is cleared by an edge that samples `hot_120` = 0 and `hot_100` = 0, and is held otherwise. Setting wins if the flags disagree. While the flag is set, `pg_pull_low` = 1. Flag encoding: each `hot_N` is 1 when the die is above N °C.
- R6: `thermal_shutdown` is set by an edge that samples `hot_150` = 1. It is cleared by an edge that samples `hot_150` = 0 and `hot_130` = 0, and is held otherwise. Setting wins.
- R7: An edge that samples `fault_active` = 1 makes `pg_pull_low` 1 from the next cycle. An `ss_done` pulse in the same cycle as an active fault is ignored.
- R8: Once a fault has pulled power good low, `pg_pull_low` stays 1 after `fault_active` returns to 0, until a new `ss_done` pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| ss_done | input | 1 | Pulse: soft-start completed successfully |
| fault_active | input | 1 | High while any fault is being handled |
| ilim_active | input | 1 | High while the current limit is engaged |
| hot_120 | input | 1 | Die above 120 °C (warning set) |
| hot_100 | input | 1 | Die above 100 °C (warning hold) |
| hot_150 | input | 1 | Die above 150 °C (shutdown set) |
| hot_130 | input | 1 | Die above 130 °C (shutdown hold) |
| pg_pull_low | output | 1 | 1 = drive the power-good pad low |
| thermal_shutdown | output | 1 | 1 = request thermal shutdown |

## Verification
The properties assume that every input is already synchronous to `clk` and is sampled only at rising edges. They also assume that `ss_done` counts as a soft-start completion in any cycle where it is high. The properties do not assume that the comparator flags are ordered, for example that `hot_120` implies `hot_100`, because the set-wins rule covers every combination. The bench changes every input on the falling edge. Its hysteresis sweeps apply all four flag combinations from both stored states, and this deliberately includes the combinations that a real sensor could not produce.

// File: rtl/pgts_pkg.sv
// Shared definitions for the power-good / thermal supervisor.
// Assumes: nothing beyond standard SystemVerilog packed types.
package pgts_pkg;

    // Inputs of one hysteretic temperature flag: the upper comparator sets
    // it, the lower comparator keeps it set.
    typedef struct packed {
        logic set_hot;
        logic keep_hot;
    } hyst_in_t;

    // Number of hysteretic flags and their slots.
    localparam int NUM_THERM = 2;
    localparam int WARN_IDX  = 0;
    localparam int SHUT_IDX  = 1;

    // Default persistence of the current-limit filter, in microsecond ticks.
    localparam int ILIM_HOLD_DEFAULT = 64;

endpackage

// File: rtl/pgts_ilim_filter.sv
// Current-limit persistence filter.
// Counts microsecond ticks while the current limit stays engaged, and raises
// trip once HOLD_TICKS ticks have been seen without a break. Any cycle with
// the limit released clears the count.
// Assumes: tick is a single-cycle strobe synchronous to clk; HOLD_TICKS >= 1.
module pgts_ilim_filter #(
    parameter int HOLD_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ilim,
    output logic trip
);
    localparam int              CW    = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0]   LIMIT = CW'(HOLD_TICKS);

    logic [CW-1:0] cnt;

    // Saturating tick counter, cleared whenever the limit is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!ilim) begin
            cnt <= '0;
        end else if (tick && (cnt != LIMIT)) begin
            cnt <= cnt + CW'(1);
        end
    end

    // The filter has tripped once the count has reached the limit.
    always_comb begin
        trip = (cnt == LIMIT);
    end
endmodule

// File: rtl/pgts_hyst_flag.sv
// Hysteretic temperature flag.
// Set by the upper comparator, held while the lower comparator stays high,
// cleared once both are low. Setting wins over clearing.
// Assumes: comparator flags are synchronous to clk.
module pgts_hyst_flag
    import pgts_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hyst_in_t cmp,
    output logic     hot
);
    // Set/hold/clear state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot <= 1'b0;
        end else if (cmp.set_hot) begin
            hot <= 1'b1;
        end else if (!cmp.keep_hot) begin
            hot <= 1'b0;
        end
    end
endmodule

// File: rtl/pgts_pg_gate.sv
// Power-good gate.
// Arms on a soft-start completion pulse and disarms on any fault, so a fault
// keeps power good low until the next completed soft-start. The pad is
// pulled low while disarmed, while the current-limit filter has tripped, or
// while the thermal warning is set.
// Assumes: ss_done and fault are synchronous to clk.
module pgts_pg_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_done,
    input  logic fault,
    input  logic ilim_trip,
    input  logic warn,
    output logic armed,
    output logic pull_low
);
    // Arm on soft-start completion. A fault disarms and has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (fault) begin
            armed <= 1'b0;
        end else if (ss_done) begin
            armed <= 1'b1;
        end
    end

    // Combine the causes that pull the pad low.
    always_comb begin
        pull_low = !armed || ilim_trip || warn;
    end
endmodule

// File: rtl/pgts_supervisor.sv
// Power-good and thermal supervisor, top level.
// Joins the current-limit filter, two hysteretic temperature flags (early
// warning and shutdown) and the power-good gate.
// Assumes: all inputs are synchronous to clk; us_tick pulses once per us.
module pgts_supervisor
    import pgts_pkg::*;
#(
    parameter int ILIM_HOLD_US = ILIM_HOLD_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic ss_done,
    input  logic fault_active,
    input  logic ilim_active,
    input  logic hot_120,
    input  logic hot_100,
    input  logic hot_150,
    input  logic hot_130,
    output logic pg_pull_low,
    output logic thermal_shutdown
);
    hyst_in_t               cmp_in [NUM_THERM];
    logic [NUM_THERM-1:0]   hot_st;
    logic                   ilim_trip;
    logic                   therm_warn;
    logic                   pg_armed;

    // Route the comparator pairs to their flag slots.
    always_comb begin
        cmp_in[WARN_IDX] = '{set_hot: hot_120, keep_hot: hot_100};
        cmp_in[SHUT_IDX] = '{set_hot: hot_150, keep_hot: hot_130};
    end

    pgts_ilim_filter #(
        .HOLD_TICKS(ILIM_HOLD_US)
    ) u_ilim (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (us_tick),
        .ilim (ilim_active),
        .trip (ilim_trip)
    );

    for (genvar g = 0; g < NUM_THERM; g++) begin : g_therm
        pgts_hyst_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .cmp  (cmp_in[g]),
            .hot  (hot_st[g])
        );
    end

    // Name the two flags.
    always_comb begin
        therm_warn       = hot_st[WARN_IDX];
        thermal_shutdown = hot_st[SHUT_IDX];
    end

    pgts_pg_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_done  (ss_done),
        .fault    (fault_active),
        .ilim_trip(ilim_trip),
        .warn     (therm_warn),
        .armed    (pg_armed),
        .pull_low (pg_pull_low)
    );
endmodule

// File: rtl/pgts_supervisor_chk.sv
// Property checker for pgts_supervisor, attached by bind below.
// Assumes: inputs sampled at rising edges of clk.
module pgts_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic ss_done,
    input logic fault_active,
    input logic ilim_active,
    input logic hot_120,
    input logic hot_100,
    input logic hot_150,
    input logic hot_130,
    input logic pg_pull_low,
    input logic thermal_shutdown,
    input logic ilim_trip,
    input logic therm_warn,
    input logic pg_armed
);
    // R1: reset forces the safe output state.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pg_pull_low && !thermal_shutdown));

    // R2 / R8: arming only follows a sampled soft-start completion.
    a_r2_arm_needs_ss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_armed) |-> $past(ss_done));

    // R3: the filter can only be tripped while the limit was engaged.
    a_r3_trip_needs_ilim: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_trip |-> $past(ilim_active));

    // R4: releasing the limit clears the trip on the next cycle.
    a_r4_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ilim_active |=> !ilim_trip);

    // R5: warning set, hold and clear.
    a_r5_warn_set: assert property (@(posedge clk) disable iff (!rst_n)
        hot_120 |=> (therm_warn && pg_pull_low));
    a_r5_warn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_warn && hot_100) |=> therm_warn);
    a_r5_warn_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_120 && !hot_100) |=> !therm_warn);

    // R6: shutdown set, hold and clear.
    a_r6_sd_set: assert property (@(posedge clk) disable iff (!rst_n)
        hot_150 |=> thermal_shutdown);
    a_r6_sd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (thermal_shutdown && hot_130) |=> thermal_shutdown);
    a_r6_sd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_150 && !hot_130) |=> !thermal_shutdown);

    // R7: a fault pulls power good low on the next cycle.
    a_r7_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
        fault_active |=> pg_pull_low);

    // R8: without a new soft-start, a disarmed gate stays disarmed.
    a_r8_stay_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!pg_armed && !ss_done) |=> !pg_armed);
endmodule

bind pgts_supervisor pgts_supervisor_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ss_done         (ss_done),
    .fault_active    (fault_active),
    .ilim_active     (ilim_active),
    .hot_120         (hot_120),
    .hot_100         (hot_100),
    .hot_150         (hot_150),
    .hot_130         (hot_130),
    .pg_pull_low     (pg_pull_low),
    .thermal_shutdown(thermal_shutdown),
    .ilim_trip       (ilim_trip),
    .therm_warn      (therm_warn),
    .pg_armed        (pg_armed)
);

// File: tb/pgts_supervisor_test.sv
`timescale 1ns/1ps
module pgts_supervisor_test;
    localparam int HOLD = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0, ss_done = 1'b0, fault_active = 1'b0, ilim_active = 1'b0;
    logic hot_120 = 1'b0, hot_100 = 1'b0, hot_150 = 1'b0, hot_130 = 1'b0;
    logic pg_pull_low, thermal_shutdown;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    pgts_supervisor #(.ILIM_HOLD_US(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ss_done(ss_done),
        .fault_active(fault_active), .ilim_active(ilim_active),
        .hot_120(hot_120), .hot_100(hot_100), .hot_150(hot_150), .hot_130(hot_130),
        .pg_pull_low(pg_pull_low), .thermal_shutdown(thermal_shutdown)
    );

    // Advance n rising edges, then stop on the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ss_pulse();
        ss_done = 1'b1;
        step(1);
        ss_done = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(3);
        check("R1 pg after reset", pg_pull_low, 1'b1);
        check("R1 sd after reset", thermal_shutdown, 1'b0);
        rst_n = 1'b1;
        step(5);
        check("R2 pg before soft-start", pg_pull_low, 1'b1);
        ss_pulse();
        check("R2 pg released by soft-start", pg_pull_low, 1'b0);

        // R3/R4: sweep every hold length around the limit, tick each cycle.
        for (int n = 0; n <= HOLD + 6; n++) begin
            ilim_active = 1'b1;
            us_tick = 1'b1;
            if (n > 0) step(n);
            check("R3 ilim hold sweep", pg_pull_low, (n >= HOLD));
            ilim_active = 1'b0;
            us_tick = 1'b0;
            step(1);
            check("R4 release after hold", pg_pull_low, 1'b0);
        end

        // R3: sparse ticks, only ticks count.
        ilim_active = 1'b1;
        for (int i = 0; i < HOLD - 1; i++) begin
            us_tick = 1'b1; step(1);
            us_tick = 1'b0; step(1);
        end
        check("R3 sparse ticks below limit", pg_pull_low, 1'b0);
        step(200);
        check("R3 no ticks no trip", pg_pull_low, 1'b0);
        us_tick = 1'b1; step(1); us_tick = 1'b0;
        check("R3 sparse ticks at limit", pg_pull_low, 1'b1);
        ilim_active = 1'b0; step(1);

        // R4: a one-cycle break restarts the count.
        ilim_active = 1'b1; us_tick = 1'b1;
        step(HOLD - 10);
        ilim_active = 1'b0; step(1);
        ilim_active = 1'b1;
        step(HOLD - 10);
        check("R4 break restarts count", pg_pull_low, 1'b0);
        step(10);
        check("R4 full hold after break", pg_pull_low, 1'b1);
        ilim_active = 1'b0; us_tick = 1'b0; step(1);

        // R5: all flag combinations from both stored states.
        for (int st = 0; st < 2; st++) begin
            for (int c = 0; c < 4; c++) begin
                hot_120 = (st == 1); hot_100 = (st == 1); step(1);
                hot_120 = c[1]; hot_100 = c[0]; step(1);
                check("R5 warning hysteresis", pg_pull_low, c[1] | (c[0] & (st == 1)));
                hot_120 = 1'b0; hot_100 = 1'b0; step(1);
                check("R5 warning cleared", pg_pull_low, 1'b0);
            end
        end

        // R6: same sweep on the shutdown flag.
        for (int st = 0; st < 2; st++) begin
            for (int c = 0; c < 4; c++) begin
                hot_150 = (st == 1); hot_130 = (st == 1); step(1);
                hot_150 = c[1]; hot_130 = c[0]; step(1);
                check("R6 shutdown hysteresis", thermal_shutdown, c[1] | (c[0] & (st == 1)));
                hot_150 = 1'b0; hot_130 = 1'b0; step(1);
                check("R6 shutdown cleared", thermal_shutdown, 1'b0);
            end
        end

        // R7/R8: fault handling.
        fault_active = 1'b1; step(1);
        check("R7 fault pulls low", pg_pull_low, 1'b1);
        ss_pulse();
        check("R7 soft-start ignored during fault", pg_pull_low, 1'b1);
        fault_active = 1'b0; step(4);
        check("R8 low after fault ends", pg_pull_low, 1'b1);
        ss_pulse();
        check("R8 released by new soft-start", pg_pull_low, 1'b0);

        // R1: reset in mid-operation.
        hot_150 = 1'b1; step(1);
        check("R6 shutdown set", thermal_shutdown, 1'b1);
        rst_n = 1'b0; step(1);
        check("R1 sd cleared by reset", thermal_shutdown, 1'b0);
        check("R1 pg low by reset", pg_pull_low, 1'b1);
        hot_150 = 1'b0; rst_n = 1'b1; step(1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule